// File: doc/BRIEF.md
# Octal DAC Channel Register Controller

This block is the digital register core of an eight-channel digital-to-analog converter. A serial front end, outside this block, decodes each frame into a command nibble, an address nibble and a 16-bit data field. Those frames arrive here on a valid/ready port. Each channel has two stages. An input register takes new codes. A DAC register drives the channel's output code. Codes move from the first stage to the second through frame commands, through an active-low load pin, or through a per-channel software override of that pin.

An active-low clear pin forces every input and DAC register to a software-selected clear value. Frame commands also set a per-channel power-down mode and an internal-reference enable bit. A software reset command returns the whole block to its reset state. The output resolution is a parameter. Narrower codes are taken from the most significant bits of the 16-bit data field.

Back-pressure is simple. `frm_ready` is high except while the synchronized clear pin is asserted. A frame is executed on the rising clock edge where `frm_valid` and `frm_ready` are both high. A source holding `frm_valid` must keep its fields stable until that edge.

Top module: `octdac_regctl`

## Requirements
- R1: After `rst_n` is released, every DAC code equals the reset code: zero, or the midscale value (only the MSB set) when `RST_MID`=1. All power-down modes read 00 and `ref_en` is 0. The override mask and the clear-select value are both 0.
- R2: Address values 0 to 7 select channels A to H, and address 15 selects all channels. A channel-directed command sent to any other address changes no register.
- R3: Command 0 writes the input register of the addressed channel and marks it pending. While the synchronized load pin is high and that channel's override bit is 0, its DAC code does not change.
- R4: Command 1 copies the input register into the DAC register of the addressed channel. Command 3 writes the input register and the DAC register together. For both commands the new code appears on `dac_codes` right after the accepting edge.
- R5: Command 2 writes the input register of the addressed channel. On the same edge it copies every channel's input register, including the new value, into its DAC register.
- R6: The load pin is synchronized through `SYNC_STAGES` flops. On every edge where the synchronized pin is low, each pending channel copies its input register into its DAC register. When the pin is held low, a write therefore reaches the output one edge after it is accepted.
- R7: Command 6 loads the override mask from data bits 7:0, where bit i is channel i and bit 0 is channel A. A channel whose bit is 1 updates from pending data as if the load pin were low.
- R8: Command 5 loads the clear-select value from data bits 1:0: 00 selects 0000h, 01 selects 8000h, 10 selects FFFFh and 11 selects no operation. While the synchronized clear pin is low, `frm_ready` is 0. Unless the select is 11, every input and DAC register also takes the selected value and pending flags are dropped.
- R9: Command 4 takes a mode from data bits 9:8 (00 normal, 01 1 kOhm to ground, 10 100 kOhm to ground, 11 three-state). It applies that mode to every channel whose bit is set in data bits 7:0. Channel i's mode appears on `pd_modes[2i+1:2i]`, and the modes of channels not selected are kept.
- R10: DAC registers keep their codes and continue to take updates while powered down. After a channel is powered up, it shows its latest input value if the load pin was low, or its earlier DAC value if the pin was high.
- R11: Command 8 sets `ref_en` to data bit 0.
- R12: Command 7 returns every register to the state given in R1.
- R13: Commands 9 to 15 change no register.
- R14: With `RES` below 16, codes are taken from data bits 15 down to 16-`RES`, and clear values are truncated the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame fields are valid |
| frm_ready | output | 1 | Frame can be accepted (low during clear) |
| frm_cmd | input | 4 | Frame command |
| frm_addr | input | 4 | Frame channel address |
| frm_data | input | 16 | Frame data field |
| load_n | input | 1 | Active-low load pin, asynchronous |
| clr_n | input | 1 | Active-low clear pin, asynchronous |
| dac_codes | output | NCH*RES | DAC register codes, channel i at bits [i*RES +: RES] |
| pd_modes | output | 2*NCH | Power-down mode per channel, channel i at bits [2i+1:2i] |
| ref_en | output | 1 | Internal reference enable |

## Verification
The bench builds the block with `RES`=12 and `RST_MID`=1, so the reset code is 800h. At this width the truncation of data fields and clear values (R14) becomes visible. Midscale reset is also told apart from the zero clear value, and the FFFh clear value is told apart from codes written by frames. The default eight channels and two-stage synchronizer let the bench check broadcast addressing, rejection of unused addresses, and pin-driven updates with a fixed wait.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

  typedef enum logic [3:0] {
    OP_WR_IN      = 4'h0,
    OP_UPD        = 4'h1,
    OP_WR_UPD_ALL = 4'h2,
    OP_WR_UPD     = 4'h3,
    OP_PWR        = 4'h4,
    OP_CLRSEL     = 4'h5,
    OP_OVR        = 4'h6,
    OP_SRST       = 4'h7,
    OP_REF        = 4'h8
  } op_e;

  localparam logic [3:0] ADDR_ALL = 4'hF;

  function automatic logic [15:0] clr_word(input logic [1:0] sel);
    case (sel)
      2'b00:   clr_word = 16'h0000;
      2'b01:   clr_word = 16'h8000;
      default: clr_word = 16'hFFFF;
    endcase
  endfunction

endpackage

// File: rtl/octdac_sync.sv
module octdac_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/octdac_decode.sv
module octdac_decode
  import octdac_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           acc,
  input  logic [3:0]     cmd,
  input  logic [3:0]     addr,
  output logic [NCH-1:0] wr_mask,
  output logic [NCH-1:0] upd_mask,
  output logic           pwr_we,
  output logic           csel_we,
  output logic           ovr_we,
  output logic           srst,
  output logic           ref_we
);
  logic [NCH-1:0] sel;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      sel[i] = (addr == ADDR_ALL) || (addr == 4'(i));
  end

  always_comb begin
    wr_mask  = '0;
    upd_mask = '0;
    pwr_we   = 1'b0;
    csel_we  = 1'b0;
    ovr_we   = 1'b0;
    srst     = 1'b0;
    ref_we   = 1'b0;
    if (acc) begin
      case (cmd)
        OP_WR_IN:      wr_mask = sel;
        OP_UPD:        upd_mask = sel;
        OP_WR_UPD_ALL: begin wr_mask = sel; upd_mask = '1; end
        OP_WR_UPD:     begin wr_mask = sel; upd_mask = sel; end
        OP_PWR:        pwr_we  = 1'b1;
        OP_CLRSEL:     csel_we = 1'b1;
        OP_OVR:        ovr_we  = 1'b1;
        OP_SRST:       srst    = 1'b1;
        OP_REF:        ref_we  = 1'b1;
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/octdac_chan.sv
module octdac_chan #(
  parameter int              RES      = 16,
  parameter logic [RES-1:0]  RST_CODE = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           srst,
  input  logic           clr_load,
  input  logic [RES-1:0] clr_code,
  input  logic           wr,
  input  logic [RES-1:0] wr_code,
  input  logic           upd_frame,
  input  logic           auto_en,
  output logic [RES-1:0] dac_q
);
  logic [RES-1:0] in_q;
  logic           pend_q;
  logic           auto_take;

  assign auto_take = pend_q && auto_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= RST_CODE;
      dac_q  <= RST_CODE;
      pend_q <= 1'b0;
    end else if (srst) begin
      in_q   <= RST_CODE;
      dac_q  <= RST_CODE;
      pend_q <= 1'b0;
    end else if (clr_load) begin
      in_q   <= clr_code;
      dac_q  <= clr_code;
      pend_q <= 1'b0;
    end else begin
      if (wr) in_q <= wr_code;
      if (upd_frame) begin
        dac_q  <= wr ? wr_code : in_q;
        pend_q <= 1'b0;
      end else begin
        if (auto_take) dac_q <= in_q;
        pend_q <= wr || (pend_q && !auto_en);
      end
    end
  end

  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_frame && !auto_take && !clr_load && !srst) |=> $stable(dac_q));

  // R4
  frame_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_frame && !wr && !clr_load && !srst) |=> (dac_q == $past(in_q)));
endmodule

// File: rtl/octdac_cfg.sv
module octdac_cfg #(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             pwr_we,
  input  logic             csel_we,
  input  logic             ovr_we,
  input  logic             ref_we,
  input  logic [15:0]      data,
  output logic [NCH-1:0]   ovr_q,
  output logic [1:0]       csel_q,
  output logic [2*NCH-1:0] pd_q,
  output logic             ref_q
);
  logic [2*NCH-1:0] pd_d;

  always_comb begin
    pd_d = pd_q;
    for (int i = 0; i < NCH; i++)
      if (pwr_we && data[i]) pd_d[2*i +: 2] = data[9:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= '0;
      csel_q <= 2'b00;
      pd_q   <= '0;
      ref_q  <= 1'b0;
    end else if (srst) begin
      ovr_q  <= '0;
      csel_q <= 2'b00;
      pd_q   <= '0;
      ref_q  <= 1'b0;
    end else begin
      if (ovr_we)  ovr_q  <= data[NCH-1:0];
      if (csel_we) csel_q <= data[1:0];
      if (ref_we)  ref_q  <= data[0];
      pd_q <= pd_d;
    end
  end

  // R9
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_we && !srst) |=> $stable(pd_q));

  // R12
  srst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ovr_q == '0 && csel_q == 2'b00 && pd_q == '0 && !ref_q));
endmodule

// File: rtl/octdac_regctl.sv
module octdac_regctl
  import octdac_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int RES         = 16,
  parameter bit RST_MID     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  output logic               frm_ready,
  input  logic [3:0]         frm_cmd,
  input  logic [3:0]         frm_addr,
  input  logic [15:0]        frm_data,
  input  logic               load_n,
  input  logic               clr_n,
  output logic [NCH*RES-1:0] dac_codes,
  output logic [2*NCH-1:0]   pd_modes,
  output logic               ref_en
);
  localparam logic [RES-1:0] RST_CODE = RST_MID ? {1'b1, {(RES-1){1'b0}}} : '0;

  logic [1:0]     pins_s;
  logic           load_s, clr_s;
  logic           acc;
  logic [NCH-1:0] wr_mask, upd_mask, ovr;
  logic           pwr_we, csel_we, ovr_we, srst, ref_we;
  logic [1:0]     csel;
  logic [15:0]    clr_full;
  logic [RES-1:0] clr_code, wr_code;
  logic           clr_load;

  octdac_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async({clr_n, load_n}), .q_sync(pins_s)
  );
  assign load_s = pins_s[0];
  assign clr_s  = pins_s[1];

  assign frm_ready = clr_s;
  assign acc       = frm_valid && frm_ready;

  octdac_decode #(.NCH(NCH)) u_dec (
    .acc(acc), .cmd(frm_cmd), .addr(frm_addr),
    .wr_mask(wr_mask), .upd_mask(upd_mask),
    .pwr_we(pwr_we), .csel_we(csel_we), .ovr_we(ovr_we),
    .srst(srst), .ref_we(ref_we)
  );

  octdac_cfg #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .pwr_we(pwr_we), .csel_we(csel_we), .ovr_we(ovr_we), .ref_we(ref_we),
    .data(frm_data),
    .ovr_q(ovr), .csel_q(csel), .pd_q(pd_modes), .ref_q(ref_en)
  );

  assign clr_full = clr_word(csel);
  assign clr_code = clr_full[15 -: RES];
  assign wr_code  = frm_data[15 -: RES];
  assign clr_load = !clr_s && (csel != 2'b11);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    octdac_chan #(.RES(RES), .RST_CODE(RST_CODE)) u_ch (
      .clk(clk), .rst_n(rst_n), .srst(srst),
      .clr_load(clr_load), .clr_code(clr_code),
      .wr(wr_mask[g]), .wr_code(wr_code),
      .upd_frame(upd_mask[g]),
      .auto_en(!load_s || ovr[g]),
      .dac_q(dac_codes[g*RES +: RES])
    );
  end

  // R13
  reserved_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && frm_cmd >= 4'h9) |=> ($stable(pd_modes) && $stable(ref_en)));

  // R8
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> ($stable(pd_modes) && $stable(ref_en)));
endmodule

// File: tb/octdac_regctl_bench.sv
module octdac_regctl_bench;
  localparam int NCH = 8;
  localparam int RES = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic frm_ready;
  logic [3:0] frm_cmd = '0, frm_addr = '0;
  logic [15:0] frm_data = '0;
  logic load_n = 1'b1, clr_n = 1'b1;
  logic [NCH*RES-1:0] dac_codes;
  logic [2*NCH-1:0] pd_modes;
  logic ref_en;

  int n_chk = 0, n_bad = 0;
  int exp_c [NCH];
  bit done = 1'b0;

  always #4 clk = ~clk;

  octdac_regctl #(.NCH(NCH), .RES(RES), .RST_MID(1'b1), .SYNC_STAGES(2)) u_octdac_regctl (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_cmd(frm_cmd), .frm_addr(frm_addr), .frm_data(frm_data),
    .load_n(load_n), .clr_n(clr_n), .dac_codes(dac_codes),
    .pd_modes(pd_modes), .ref_en(ref_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_codes(input string req);
    for (int i = 0; i < NCH; i++)
      chk(req, int'(dac_codes[i*RES +: RES]), exp_c[i]);
  endtask

  task automatic set_all(input int v);
    for (int i = 0; i < NCH; i++) exp_c[i] = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!frm_ready) @(negedge clk);
    frm_valid = 1'b1; frm_cmd = c; frm_addr = a; frm_data = d;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic t_reset;
    set_all(12'h800);
    chk_codes("R1 reset code");
    chk("R1 pd reset", int'(pd_modes), 0);
    chk("R1 ref reset", int'(ref_en), 0);
    chk("R8 ready idle", int'(frm_ready), 1);
  endtask

  task automatic t_load_pin;
    send(4'h0, 4'd2, 16'h1230);
    wait_cyc(3);
    chk_codes("R3 write input only");
    load_n = 1'b0; wait_cyc(4); load_n = 1'b1; wait_cyc(4);
    exp_c[2] = 12'h123;
    chk_codes("R6 load pulse");
  endtask

  task automatic t_update;
    send(4'h0, 4'd0, 16'hABC0);
    wait_cyc(2);
    chk_codes("R3 pending held");
    send(4'h1, 4'd0, 16'h0000);
    exp_c[0] = 12'hABC;
    chk_codes("R4 update cmd");
    send(4'h3, 4'd7, 16'h5550);
    exp_c[7] = 12'h555;
    chk_codes("R4 write and update");
  endtask

  task automatic t_upd_all;
    send(4'h0, 4'd1, 16'h2220);
    send(4'h2, 4'd4, 16'h4440);
    exp_c[1] = 12'h222; exp_c[4] = 12'h444;
    chk_codes("R5 write n update all");
    send(4'h3, 4'hF, 16'h7770);
    set_all(12'h777);
    chk_codes("R2 broadcast address");
    send(4'h3, 4'h8, 16'h4560);
    wait_cyc(2);
    chk_codes("R2 unused address");
  endtask

  task automatic t_override;
    send(4'h6, 4'd0, 16'h0008);
    send(4'h0, 4'd3, 16'h9990);
    send(4'h0, 4'd6, 16'h6660);
    wait_cyc(3);
    exp_c[3] = 12'h999;
    chk_codes("R7 override mask");
    send(4'h6, 4'd0, 16'h0000);
  endtask

  task automatic t_clear;
    send(4'h5, 4'd0, 16'h0002);
    clr_n = 1'b0; wait_cyc(3);
    chk("R8 ready low in clear", int'(frm_ready), 0);
    wait_cyc(3);
    set_all(12'hFFF);
    chk_codes("R14 clear FFFF truncated");
    clr_n = 1'b1; wait_cyc(4);
    chk("R8 ready after clear", int'(frm_ready), 1);
    send(4'h1, 4'hF, 16'h0000);
    chk_codes("R8 inputs cleared");
    send(4'h3, 4'hF, 16'h1000);
    set_all(12'h100);
    send(4'h5, 4'd0, 16'h0003);
    clr_n = 1'b0; wait_cyc(6); clr_n = 1'b1; wait_cyc(4);
    chk_codes("R8 clear select nop");
    send(4'h5, 4'd0, 16'h0001);
    clr_n = 1'b0; wait_cyc(6); clr_n = 1'b1; wait_cyc(4);
    set_all(12'h800);
    chk_codes("R8 clear midscale");
  endtask

  task automatic t_power;
    send(4'h4, 4'd0, 16'h0281);
    chk("R9 pd modes", int'(pd_modes), 16'h8002);
    chk_codes("R10 codes kept in pd");
    load_n = 1'b0;
    send(4'h0, 4'd0, 16'h1110);
    wait_cyc(4);
    load_n = 1'b1; wait_cyc(4);
    send(4'h0, 4'd7, 16'h3330);
    wait_cyc(3);
    send(4'h4, 4'd0, 16'h0081);
    chk("R9 power up", int'(pd_modes), 0);
    exp_c[0] = 12'h111;
    chk_codes("R10 power up codes");
  endtask

  task automatic t_ref_reserved;
    send(4'h8, 4'd0, 16'h0001);
    chk("R11 ref on", int'(ref_en), 1);
    send(4'h8, 4'd0, 16'h0000);
    chk("R11 ref off", int'(ref_en), 0);
    send(4'h8, 4'd0, 16'h0001);
    send(4'h4, 4'd0, 16'h0310);
    chk("R9 tri-state ch E", int'(pd_modes), 16'h0300);
    send(4'h9, 4'hF, 16'hFFFF);
    send(4'hF, 4'hF, 16'hFFFF);
    wait_cyc(3);
    chk("R13 reserved pd", int'(pd_modes), 16'h0300);
    chk("R13 reserved ref", int'(ref_en), 1);
    chk_codes("R13 reserved codes");
  endtask

  task automatic t_soft_reset;
    send(4'h6, 4'd0, 16'h0008);
    send(4'h7, 4'd0, 16'h0000);
    set_all(12'h800);
    chk_codes("R12 soft reset codes");
    chk("R12 soft reset pd", int'(pd_modes), 0);
    chk("R12 soft reset ref", int'(ref_en), 0);
    send(4'h0, 4'd3, 16'h2340);
    wait_cyc(3);
    chk_codes("R12 override cleared");
    load_n = 1'b0; wait_cyc(4);
    exp_c[3] = 12'h234;
    chk_codes("R6 load held low");
    send(4'h0, 4'd5, 16'hCDE0);
    wait_cyc(2);
    exp_c[5] = 12'hCDE;
    chk_codes("R6 held low follows write");
    load_n = 1'b1;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_load_pin();
    t_update();
    t_upd_all();
    t_override();
    t_clear();
    t_power();
    t_ref_reserved();
    t_soft_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule